// File: doc/BRIEF.md
# Overeager Load Dependence Predictor

This block learns which loads have a habit of running ahead of an older store whose data they needed, and makes those loads wait. Before a load enters the scheduler, the front end presents its PC on the lookup port. The block answers in the same cycle with one bit: eager (free to issue out of order) or overeager (must wait). When the load/store unit finds that a load missed a forward from the store buffer, it sends that load's PC on the training port, and the load is marked from then on.

The mark is kept in a direct-mapped table of 256 entries. Each entry holds a valid bit and a partial-PC tag, and only a tag match counts as a prediction. A bulk clear input drops every mark at once, so that stale marks do not persist. The block does not try to name the store a marked load depends on. For each scheduler entry it raises a hold output while the entry carries an overeager load and any older store still has its address op or its data op outstanding. Unmarked loads never see a hold and stay fully free to reorder.

Top module: `oel_predictor`

## Requirements
- R1: Out of reset every table entry is invalid, so every lookup returns eager (lk_overeager = 0).
- R2: After a training write of a PC with no clear in that cycle, a later lookup of the same PC returns overeager (1), as long as no other PC with the same index has been trained since and no clear has occurred.
- R3: The table is direct-mapped. A lookup whose index matches a valid entry but whose tag differs returns eager. Training a second PC with the same index replaces the first, so the first PC then looks up as eager.
- R4: The index is PC bits [9:2] and the tag is PC bits [17:10]. PC bits [1:0] and bits [31:18] have no effect, so PCs that differ only there alias to the same prediction.
- R5: When a training write and a lookup fall on the same index in one cycle, the lookup already sees the trained entry: overeager if the tags match, eager if they differ.
- R6: A clear invalidates all entries. A lookup in the clear cycle already sees the cleared table. A training write in the clear cycle survives the clear, and that cycle's lookup also sees it.
- R7: hold[i] is 1 when scheduler entry i is valid and marked overeager and, for some store j with ent_older_st[i][j] = 1, st_addr_issued[j] = 0 or st_data_issued[j] = 0.
- R8: hold[i] is 0 when entry i is invalid, when it is not marked overeager, or when every older store of entry i has both st_addr_issued and st_data_issued set. Stores that are not older (mask bit 0) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_all | input | 1 | Invalidate every table entry |
| lk_pc | input | 32 | PC of the load being inserted |
| lk_overeager | output | 1 | 1 = hold this load, 0 = eager |
| train_valid | input | 1 | Training write strobe from the load/store unit |
| train_pc | input | 32 | PC of the load that failed to forward |
| ent_valid | input | 8 | Scheduler entry holds a load |
| ent_overeager | input | 8 | Scheduler entry's load was predicted overeager |
| ent_older_st | input | 8x8 | Per scheduler entry, mask of stores older than its load |
| st_addr_issued | input | 8 | Store-address op of each store entry has issued |
| st_data_issued | input | 8 | Store-data op of each store entry has issued |
| hold | output | 8 | Per scheduler entry, keep the load from issuing |

## Verification
Lookups are tried with PCs drawn from a narrow band of indices, so that tag hits, tag misses on a shared index and entry replacement all occur often. These cases separate a correct tag compare from one that looks at the index alone. Directed steps cover aliasing in the ignored PC bits, a lookup in the same cycle as a training write, and training during a clear. Together they tell whether the bypass goes in the right direction and whether clear and train are applied in the right order. Hold is driven with random older-store masks in which the address and data issue bits are set independently. This shows whether both ops are required, and whether stores that are not older are ignored.

// File: rtl/oel_pkg.sv
// Shared definitions for the overeager load predictor.
// Assumes nothing beyond a 1800-2017 tool; widths stay as module parameters.
package oel_pkg;
    // Prediction outcome carried between table and top.
    typedef enum logic {
        OEL_EAGER = 1'b0,
        OEL_HOLD  = 1'b1
    } oel_pred_e;
endpackage

// File: rtl/oel_table.sv
// Direct-mapped table of overeager marks, indexed and tagged by load PC.
// Assumes word-aligned PCs (LSB bits dropped); the training write and the
// bulk clear are visible to a lookup in the same cycle (clear, then train).
module oel_table
    import oel_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int LSB   = 2,
    parameter int IDX_W = 8,
    parameter int TAG_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_all,
    input  logic            train_valid,
    input  logic [PC_W-1:0] train_pc,
    input  logic [PC_W-1:0] lk_pc,
    output oel_pred_e       lk_pred
);
    localparam int DEPTH   = 1 << IDX_W;
    localparam int TAG_LSB = LSB + IDX_W;

    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [DEPTH-1:0] vld_q;

    logic [IDX_W-1:0] t_idx, l_idx;
    logic [TAG_W-1:0] t_tag, l_tag;

    // Split both PCs into index and tag fields.
    always_comb begin
        t_idx = train_pc[LSB +: IDX_W];
        t_tag = train_pc[TAG_LSB +: TAG_W];
        l_idx = lk_pc[LSB +: IDX_W];
        l_tag = lk_pc[TAG_LSB +: TAG_W];
    end

    // Update storage: reset or clear drops marks, training sets one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (clear_all)
                vld_q <= '0;
            if (train_valid) begin
                vld_q[t_idx] <= 1'b1;
                tag_q[t_idx] <= t_tag;
            end
        end
    end

    // Lookup with same-cycle clear and training folded in.
    always_comb begin
        if (train_valid && (t_idx == l_idx))
            lk_pred = (t_tag == l_tag) ? OEL_HOLD : OEL_EAGER;
        else if (clear_all || !vld_q[l_idx])
            lk_pred = OEL_EAGER;
        else
            lk_pred = (tag_q[l_idx] == l_tag) ? OEL_HOLD : OEL_EAGER;
    end
endmodule

// File: rtl/oel_hold.sv
// Per-scheduler-entry hold: an overeager load waits for every older store's
// address and data ops. Assumes the scheduler supplies the older-store mask.
module oel_hold #(
    parameter int N_SCHED = 8,
    parameter int N_ST    = 8
) (
    input  logic [N_SCHED-1:0]           ent_valid,
    input  logic [N_SCHED-1:0]           ent_overeager,
    input  logic [N_SCHED-1:0][N_ST-1:0] ent_older_st,
    input  logic [N_ST-1:0]              st_addr_issued,
    input  logic [N_ST-1:0]              st_data_issued,
    output logic [N_SCHED-1:0]           hold
);
    logic [N_ST-1:0] st_done;

    // A store is finished once both of its halves have issued.
    assign st_done = st_addr_issued & st_data_issued;

    for (genvar i = 0; i < N_SCHED; i++) begin : g_ent
        logic older_done;
        // AND-reduce over older stores; non-older stores read as done.
        assign older_done = &(~ent_older_st[i] | st_done);
        assign hold[i]    = ent_valid[i] & ent_overeager[i] & ~older_done;
    end
endmodule

// File: rtl/oel_predictor.sv
// Top of the overeager load predictor: the PC lookup/training table plus
// the per-entry hold logic toward the scheduler.
// Assumes training arrives from the load/store unit on a failed forward.
module oel_predictor
    import oel_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 8,
    parameter int TAG_W   = 8,
    parameter int N_SCHED = 8,
    parameter int N_ST    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear_all,
    input  logic [PC_W-1:0]               lk_pc,
    output logic                          lk_overeager,
    input  logic                          train_valid,
    input  logic [PC_W-1:0]               train_pc,
    input  logic [N_SCHED-1:0]            ent_valid,
    input  logic [N_SCHED-1:0]            ent_overeager,
    input  logic [N_SCHED-1:0][N_ST-1:0]  ent_older_st,
    input  logic [N_ST-1:0]               st_addr_issued,
    input  logic [N_ST-1:0]               st_data_issued,
    output logic [N_SCHED-1:0]            hold
);
    localparam int LSB = 2;

    oel_pred_e pred;

    oel_table #(
        .PC_W (PC_W),
        .LSB  (LSB),
        .IDX_W(IDX_W),
        .TAG_W(TAG_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_all  (clear_all),
        .train_valid(train_valid),
        .train_pc   (train_pc),
        .lk_pc      (lk_pc),
        .lk_pred    (pred)
    );

    // Present the prediction as a plain bit.
    assign lk_overeager = (pred == OEL_HOLD);

    oel_hold #(
        .N_SCHED(N_SCHED),
        .N_ST   (N_ST)
    ) u_hold (
        .ent_valid     (ent_valid),
        .ent_overeager (ent_overeager),
        .ent_older_st  (ent_older_st),
        .st_addr_issued(st_addr_issued),
        .st_data_issued(st_data_issued),
        .hold          (hold)
    );
endmodule

// File: rtl/oel_predictor_chk.sv
// Assertion checker for oel_predictor, attached by bind below.
module oel_predictor_chk #(
    parameter int PC_W    = 32,
    parameter int N_SCHED = 8,
    parameter int N_ST    = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          clear_all,
    input logic [PC_W-1:0]               lk_pc,
    input logic                          lk_overeager,
    input logic                          train_valid,
    input logic [PC_W-1:0]               train_pc,
    input logic [N_SCHED-1:0]            ent_valid,
    input logic [N_SCHED-1:0]            ent_overeager,
    input logic [N_SCHED-1:0][N_ST-1:0]  ent_older_st,
    input logic [N_ST-1:0]               st_addr_issued,
    input logic [N_ST-1:0]               st_data_issued,
    input logic [N_SCHED-1:0]            hold
);
    AST_TRAIN_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (train_valid && lk_pc == train_pc) |-> lk_overeager); // R5

    AST_TRAIN_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(train_valid) && !train_valid && !clear_all &&
         lk_pc == $past(train_pc)) |-> lk_overeager); // R2

    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clear_all) && !$past(train_valid) && !train_valid) |-> !lk_overeager); // R6

    AST_CLEAR_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_all && !train_valid) |-> !lk_overeager); // R6

    AST_HOLD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold & ~(ent_valid & ent_overeager)) == '0); // R8

    for (genvar i = 0; i < N_SCHED; i++) begin : g_chk
        AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
            (ent_valid[i] && ent_overeager[i] &&
             |(ent_older_st[i] & ~(st_addr_issued & st_data_issued))) |-> hold[i]); // R7
        AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            ((ent_older_st[i] & ~(st_addr_issued & st_data_issued)) == '0) |-> !hold[i]); // R8
    end
endmodule

bind oel_predictor oel_predictor_chk #(
    .PC_W   (PC_W),
    .N_SCHED(N_SCHED),
    .N_ST   (N_ST)
) u_chk (.*);

// File: tb/oel_predictor_test.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared against a reference table kept in the bench.
module oel_predictor_test;
    localparam int PC_W = 32;
    localparam int NS   = 8;
    localparam int NT   = 8;

    logic                  clk = 0;
    logic                  rst_n = 0;
    logic                  clear_all = 0;
    logic [PC_W-1:0]       lk_pc = '0;
    logic                  lk_overeager;
    logic                  train_valid = 0;
    logic [PC_W-1:0]       train_pc = '0;
    logic [NS-1:0]         ent_valid = '0;
    logic [NS-1:0]         ent_overeager = '0;
    logic [NS-1:0][NT-1:0] ent_older_st = '0;
    logic [NT-1:0]         st_addr_issued = '0;
    logic [NT-1:0]         st_data_issued = '0;
    logic [NS-1:0]         hold;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    bit       ref_v [256];
    bit [7:0] ref_t [256];

    oel_predictor uut (.*);

    always #4 clk = ~clk;  // 125 MHz

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic bit exp_lookup(bit [31:0] pc, bit tv, bit [31:0] tpc, bit clr);
        if (tv && tpc[9:2] == pc[9:2]) return tpc[17:10] == pc[17:10];
        if (clr) return 0;
        return ref_v[pc[9:2]] && ref_t[pc[9:2]] == pc[17:10];
    endfunction

    function automatic bit [NS-1:0] exp_hold();
        bit [NS-1:0] h;
        for (int i = 0; i < NS; i++) begin
            h[i] = 0;
            for (int j = 0; j < NT; j++)
                if (ent_older_st[i][j] && !(st_addr_issued[j] && st_data_issued[j])) h[i] = 1;
            h[i] = h[i] & ent_valid[i] & ent_overeager[i];
        end
        return h;
    endfunction

    task automatic chk(string req, bit [31:0] act, bit [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check before posedge, update model at posedge.
    task automatic step(string req, bit [31:0] pc, bit tv, bit [31:0] tpc, bit clr);
        @(negedge clk);
        lk_pc = pc; train_valid = tv; train_pc = tpc; clear_all = clr;
        #1;
        chk(req, {31'd0, lk_overeager}, {31'd0, exp_lookup(pc, tv, tpc, clr)});
        @(posedge clk);
        if (clr) for (int k = 0; k < 256; k++) ref_v[k] = 0;
        if (tv) begin ref_v[tpc[9:2]] = 1; ref_t[tpc[9:2]] = tpc[17:10]; end
    endtask

    function automatic bit [31:0] rpc();
        bit [31:0] p = $urandom;
        p[9:2]   = {6'd0, p[3:2]};          // few indices, many collisions
        p[17:10] = {6'd0, p[11:10]};
        return p;
    endfunction

    initial begin
        bit [31:0] pa, pb;
        void'($urandom(32'd1234));
        for (int k = 0; k < 256; k++) begin ref_v[k] = 0; ref_t[k] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1: empty after reset
        for (int n = 0; n < 8; n++) step("R1", $urandom, 0, 0, 0);

        pa = 32'h0001_2344;
        pb = 32'h0001_6344;       // same index, different tag
        step("R2", pa, 1, pa, 0); // R5 bypass too
        step("R2", pa, 0, 0, 0);
        step("R3", pb, 0, 0, 0);
        step("R3", pb, 1, pb, 0);
        step("R3", pa, 0, 0, 0);
        step("R4", pb ^ 32'hFFFC_0003, 0, 0, 0);
        step("R5", pa, 1, pa, 0);
        step("R5", pb, 1, pa, 0);
        step("R6", pa, 0, 0, 1);
        step("R6", pa, 0, 0, 0);
        step("R6", pb, 1, pb, 1);
        step("R6", pb, 0, 0, 0);

        // Random lookup/train/clear mix
        for (int n = 0; n < 3000; n++) begin
            bit tv = ($urandom % 3) == 0;
            bit cl = ($urandom % 50) == 0;
            bit [31:0] lp = rpc();
            bit [31:0] tp = (($urandom % 4) == 0) ? lp : rpc();
            step("R2_R3_R5_R6", lp, tv, tp, cl);
        end

        // R7/R8: hold logic, directed then random
        @(negedge clk);
        ent_valid = '1; ent_overeager = '1; ent_older_st = '1;
        st_addr_issued = '1; st_data_issued = 8'hFE; #1;
        chk("R7", hold, {NS{1'b1}});
        st_data_issued = '1; #1;
        chk("R8", hold, '0);
        st_addr_issued = 8'h7F; ent_overeager = 8'h0F; #1;
        chk("R8", hold, 8'h0F);
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            ent_valid = $urandom; ent_overeager = $urandom;
            for (int i = 0; i < NS; i++) ent_older_st[i] = $urandom & $urandom;
            st_addr_issued = $urandom | $urandom;
            st_data_issued = $urandom | $urandom;
            #1;
            chk("R7_R8", hold, exp_hold());
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule